// File: doc/BRIEF.md
# Multi-lane I2S master transceiver

This block is the clock master and serial engine for a wide I2S audio link. From the master clock it derives a bit clock and a word-select clock, and it shares both across a configurable number of line groups. Each group has four output data lines and four input data lines, and each line carries one stereo pair. With the default two groups the block moves sixteen channels in each direction.

At every frame boundary a one-cycle `frame_strobe` marks the moment the block latches a fresh vector of output samples. In the same cycle it releases the vector of input samples captured during the previous frame. The input side uses two frame buffers. Incoming bits are written into one buffer while the other is presented, and the roles swap at each frame boundary. Captured audio therefore appears one frame after it arrived.

A command input halts the bus. While it is high, both clocks and all data lines are held low. When it is released, the block restarts exactly as it does after reset. The number of input groups is a separate parameter, and elaboration stops with an error if it differs from the number of output groups.

Top module: `i2s_ml_master`

## Requirements
- R1: `bclk` has a period of `div_ratio` master-clock cycles, with values below 2 treated as 2. After each falling edge it is low for floor(ratio/2) cycles and high for the rest of the period.
- R2: A frame is 64 bit-clock periods: a 32-bit left slot followed by a 32-bit right slot. Each sample is sent MSB first, and `sdout` changes only in the cycle where `bclk` falls.
- R3: `lrclk` is low while the left slot is sent and high while the right slot is sent. It changes one bit-clock period before the MSB of each slot, and only on a falling `bclk`.
- R4: `frame_strobe` is a one-cycle pulse in the cycle where `bclk` falls to start the left-slot MSB. `tx_samples` and `tx_valid` are sampled at the clock edge that raises the pulse.
- R5: Channel c occupies `tx_samples[32c+31:32c]`. Output line n sends channel 2n in the left slot and channel 2n+1 in the right slot.
- R6: `sdin` is sampled at the clock edge where `bclk` rises. Bits captured on line n during a frame go to channel 2n (left slot) and 2n+1 (right slot), using the same layout as `rx_samples`. That frame is presented from the next `frame_strobe` and held unchanged until the strobe after it.
- R7: `rx_valid` is low after reset or halt. It rises with the second `frame_strobe` after that, and stays high until the next reset or halt.
- R8: In the cycle after `halt_cmd` is sampled high, `bclk`, `lrclk` and every `sdout` line are low, and they stay low while the command is held. After release the block restarts as after reset (R10).
- R9: If `tx_valid` is low when a frame is latched, every output line sends zero words for that whole frame.
- R10: After reset `sdout` is low, `bclk` is low and `lrclk` is high. `lrclk` falls at the start of the second bit-clock period, and the first `frame_strobe` comes at the start of the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ratio | input | DIV_W | Master clocks per bit-clock period |
| halt_cmd | input | 1 | Halt request; clocks and data held low while high |
| tx_samples | input | 32 x channels | Output samples, channel c at bits 32c+31..32c |
| tx_valid | input | 1 | Output vector is fresh; when low, zero words are sent |
| frame_strobe | output | 1 | One-cycle frame boundary pulse |
| rx_samples | output | 32 x channels | Input samples of the previous frame |
| rx_valid | output | 1 | `rx_samples` holds a complete frame |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word select, high for the right slot |
| sdout | output | lines | Serial output data, one bit per line |
| sdin | input | lines | Serial input data, one bit per line |

## Verification
On every cycle the assertions check the edge relations. Data and word select move only when the bit clock falls, the strobe sits on a falling bit clock, word select is already low one period before the strobe, the presented input vector never changes between strobes, and a halt silences the bus. These relations cannot show whether the bits are correct. A bench model that tracks time since reset supplies the expected bit clock, word select and per-line bit for every cycle, together with the expected captured frame. With it the bench exercises the channel-to-line mapping, one-frame input latency, zero-word frames, odd and clamped divide ratios, and restart after a halt.

// File: rtl/i2s_ml_pkg.sv
package i2s_ml_pkg;

    localparam int SLOT_W          = 32;
    localparam int FRAME_BITS      = 2 * SLOT_W;
    localparam int LINES_PER_GROUP = 4;
    localparam int CH_PER_LINE     = 2;
    localparam int BPOS_W          = $clog2(FRAME_BITS);
    localparam int SB_W            = $clog2(SLOT_W);

    typedef logic [BPOS_W-1:0] bpos_t;

    // Restart point: two periods before the first left MSB.
    localparam bpos_t BPOS_START = bpos_t'(FRAME_BITS - 2);
    localparam bpos_t BPOS_LAST  = bpos_t'(FRAME_BITS - 1);

    typedef enum logic [1:0] {ST_HALT, ST_START, ST_RUN} run_state_e;

    typedef struct packed {
        logic tick;   // bit clock falls at this edge
        logic rise;   // bit clock rises at this edge
    } bclk_ev_t;

    // Word select for a bit period: high from one period before the right MSB
    // up to one period before the next left MSB.
    function automatic logic ws_level(bpos_t k);
        return (k >= bpos_t'(SLOT_W - 1)) && (k != BPOS_LAST);
    endfunction

    function automatic logic is_right(bpos_t k);
        return k[BPOS_W-1];
    endfunction

    function automatic logic [SB_W-1:0] slot_bit(bpos_t k);
        return SB_W'(SLOT_W - 1) - k[SB_W-1:0];
    endfunction

endpackage

// File: rtl/i2s_ml_clkgen.sv
module i2s_ml_clkgen
    import i2s_ml_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             bclk,
    output bclk_ev_t         ev
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cnt_nxt;
    logic [DIV_W-1:0] ratio_eff;
    logic [DIV_W-1:0] half;

    always_comb begin
        ratio_eff = (div_ratio < DIV_W'(2)) ? DIV_W'(2) : div_ratio;
        half      = ratio_eff >> 1;
        ev.tick   = (cnt >= ratio_eff - DIV_W'(1));
        cnt_nxt   = ev.tick ? '0 : cnt + DIV_W'(1);
        ev.rise   = (cnt_nxt == half);
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else begin
            cnt  <= cnt_nxt;
            bclk <= (cnt_nxt >= half);
        end
    end

endmodule

// File: rtl/i2s_ml_tx.sv
module i2s_ml_tx
    import i2s_ml_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                                    clk,
    input  logic                                    restart,
    input  logic                                    tick,
    input  logic                                    load,
    input  logic                                    tx_valid,
    input  logic [NUM_LINES*CH_PER_LINE*SLOT_W-1:0] tx_samples,
    output logic [NUM_LINES-1:0]                    sdout
);

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        localparam int CH_L = CH_PER_LINE * n;
        localparam int CH_R = CH_PER_LINE * n + 1;

        logic [FRAME_BITS-1:0] sr;

        always_ff @(posedge clk) begin
            if (restart) begin
                sr <= '0;
            end else if (load) begin
                sr <= tx_valid ? {tx_samples[CH_L*SLOT_W +: SLOT_W],
                                  tx_samples[CH_R*SLOT_W +: SLOT_W]} : '0;
            end else if (tick) begin
                sr <= {sr[FRAME_BITS-2:0], 1'b0};
            end
        end

        assign sdout[n] = sr[FRAME_BITS-1];
    end

endmodule

// File: rtl/i2s_ml_rx.sv
module i2s_ml_rx
    import i2s_ml_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    restart,
    input  logic                                    rise,
    input  logic                                    swap,
    input  bpos_t                                   bpos,
    input  logic [NUM_LINES-1:0]                    sdin,
    output logic [NUM_LINES*CH_PER_LINE*SLOT_W-1:0] rx_samples,
    output logic                                    rx_valid
);

    localparam int VEC_W = NUM_LINES * CH_PER_LINE * SLOT_W;

    logic [1:0][VEC_W-1:0] pp;
    logic                  wr_sel;
    logic                  seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            pp       <= '0;
            wr_sel   <= 1'b0;
            seen     <= 1'b0;
            rx_valid <= 1'b0;
        end else if (restart) begin
            seen     <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            if (rise) begin
                for (int n = 0; n < NUM_LINES; n++) begin
                    pp[wr_sel][(CH_PER_LINE*n + int'(is_right(bpos)))*SLOT_W
                               + int'(slot_bit(bpos))] <= sdin[n];
                end
            end
            if (swap) begin
                wr_sel   <= ~wr_sel;
                seen     <= 1'b1;
                rx_valid <= seen;
            end
        end
    end

    assign rx_samples = pp[~wr_sel];

endmodule

// File: rtl/i2s_ml_master.sv
module i2s_ml_master
    import i2s_ml_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int RX_GROUPS  = 2,
    parameter int DIV_W      = 8,
    localparam int NUM_LINES = NUM_GROUPS * LINES_PER_GROUP,
    localparam int VEC_W     = NUM_LINES * CH_PER_LINE * SLOT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_W-1:0]     div_ratio,
    input  logic                 halt_cmd,
    input  logic [VEC_W-1:0]     tx_samples,
    input  logic                 tx_valid,
    output logic                 frame_strobe,
    output logic [VEC_W-1:0]     rx_samples,
    output logic                 rx_valid,
    output logic                 bclk,
    output logic                 lrclk,
    output logic [NUM_LINES-1:0] sdout,
    input  logic [NUM_LINES-1:0] sdin
);

    if (RX_GROUPS != NUM_GROUPS) begin : g_cfg_bad
        $error("input and output line group counts must match");
    end

    logic       restart;
    logic       frame_start;
    run_state_e st;
    bpos_t      bpos;
    bclk_ev_t   ev;

    assign restart     = rst || halt_cmd;
    assign frame_start = ev.tick && (bpos == BPOS_LAST);

    i2s_ml_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .restart   (restart),
        .div_ratio (div_ratio),
        .bclk      (bclk),
        .ev        (ev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_START;
        end else if (halt_cmd) begin
            st <= ST_HALT;
        end else begin
            case (st)
                ST_HALT:  st <= ST_START;
                ST_START: st <= ST_RUN;
                default:  st <= ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            bpos         <= BPOS_START;
            frame_strobe <= 1'b0;
        end else begin
            if (ev.tick) bpos <= bpos + bpos_t'(1);
            frame_strobe <= frame_start;
        end
    end

    assign lrclk = (st != ST_HALT) && ws_level(bpos);

    i2s_ml_tx #(.NUM_LINES(NUM_LINES)) u_tx (
        .clk        (clk),
        .restart    (restart),
        .tick       (ev.tick),
        .load       (frame_start),
        .tx_valid   (tx_valid),
        .tx_samples (tx_samples),
        .sdout      (sdout)
    );

    i2s_ml_rx #(.NUM_LINES(NUM_LINES)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .restart    (halt_cmd),
        .rise       (ev.rise),
        .swap       (frame_start),
        .bpos       (bpos),
        .sdin       (sdin),
        .rx_samples (rx_samples),
        .rx_valid   (rx_valid)
    );

    // Checks are off until one clean running cycle has passed after a restart.
    logic chk_off;
    assign chk_off = rst || (st != ST_RUN);

    assert_strobe_on_bclk_fall_R4: assert property (@(posedge clk) disable iff (chk_off)
        frame_strobe |-> $fell(bclk))
        else $error("frame strobe not on a falling bit clock");

    assert_ws_leads_msb_R3: assert property (@(posedge clk) disable iff (chk_off)
        frame_strobe |-> (!lrclk && $past(!lrclk)))
        else $error("word select did not lead the left MSB");

    assert_ws_moves_on_fall_R3: assert property (@(posedge clk) disable iff (chk_off)
        !$fell(bclk) |-> $stable(lrclk))
        else $error("word select moved off a falling bit clock");

    assert_data_moves_on_fall_R2: assert property (@(posedge clk) disable iff (chk_off)
        !$fell(bclk) |-> $stable(sdout))
        else $error("data moved off a falling bit clock");

    assert_rx_held_R6: assert property (@(posedge clk) disable iff (chk_off)
        !frame_strobe |-> $stable(rx_samples))
        else $error("presented input changed between strobes");

    assert_valid_with_strobe_R7: assert property (@(posedge clk) disable iff (chk_off)
        $rose(rx_valid) |-> frame_strobe)
        else $error("input valid rose away from a strobe");

    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        halt_cmd |=> (!bclk && !lrclk && (sdout == '0)))
        else $error("bus not silent during halt");

endmodule

// File: tb/i2s_ml_master_tb.sv
module i2s_ml_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL  = 8;
    localparam int NCH = 16;
    localparam int VW  = NCH * 32;

    logic          clk;
    logic          rst;
    logic [7:0]    div_ratio;
    logic          halt_cmd;
    logic [VW-1:0] tx_samples;
    logic          tx_valid;
    logic          frame_strobe;
    logic [VW-1:0] rx_samples;
    logic          rx_valid;
    logic          bclk;
    logic          lrclk;
    logic [NL-1:0] sdout;
    logic [NL-1:0] sdin;

    i2s_ml_master u_dut (
        .clk          (clk),
        .rst          (rst),
        .div_ratio    (div_ratio),
        .halt_cmd     (halt_cmd),
        .tx_samples   (tx_samples),
        .tx_valid     (tx_valid),
        .frame_strobe (frame_strobe),
        .rx_samples   (rx_samples),
        .rx_valid     (rx_valid),
        .bclk         (bclk),
        .lrclk        (lrclk),
        .sdout        (sdout),
        .sdin         (sdin)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk;
    int n_fail;

    // Reference model state: time since the last restart, latched frames.
    int            t;
    bit            m_halt;
    bit            m_from_rst;
    bit            m_zero;
    bit            m_valid;
    bit            e_strobe;
    int            m_strobes;
    int            rseed;
    int            tseed;
    logic [VW-1:0] m_txl;
    logic [VW-1:0] m_cap;
    logic [VW-1:0] m_rxo;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] tx_word(int s, int c);
        return (32'h9E3779B9 * 32'(s * 64 + c + 1)) ^ {s[7:0], 8'hC3, c[7:0], 8'h5A};
    endfunction

    function automatic logic [31:0] rx_word(int s, int c);
        return (32'h85EBCA6B * 32'(s * 64 + c + 3)) ^ {c[7:0], s[7:0], 16'hA50F};
    endfunction

    task automatic fill_tx();
        for (int c = 0; c < NCH; c++) tx_samples[c*32 +: 32] = tx_word(tseed, c);
    endtask

    task automatic cycle();
        int r, h, cnt, k;
        logic eb, el;
        logic [NL-1:0] es;
        string tg, tb, tl, td;
        @(posedge clk);
        #1;
        r = (div_ratio < 8'd2) ? 2 : int'(div_ratio);
        h = r / 2;
        e_strobe = 1'b0;
        if (rst || halt_cmd) begin
            t = 0;
            m_halt = halt_cmd && !rst;
            m_from_rst = rst;
            m_zero = 1'b0;
            m_valid = 1'b0;
            m_strobes = 0;
            m_txl = '0;
        end else begin
            t++;
            m_halt = 1'b0;
        end
        cnt = t % r;
        k = (62 + t / r) % 64;
        if (!rst && !halt_cmd) begin
            if (cnt == 0 && k == 0) begin
                e_strobe = 1'b1;
                m_txl = tx_valid ? tx_samples : '0;
                m_zero = !tx_valid;
                m_strobes++;
                if (m_strobes >= 2) m_valid = 1'b1;
                m_rxo = m_cap;
                rseed++;
            end
            if (cnt == h) begin
                for (int n = 0; n < NL; n++)
                    m_cap[(2*n + ((k >= 32) ? 1 : 0))*32 + 31 - (k % 32)] = sdin[n];
            end
        end
        eb = m_halt ? 1'b0 : (cnt >= h);
        el = m_halt ? 1'b0 : (k >= 31 && k <= 62);
        for (int n = 0; n < NL; n++) begin
            if (m_halt) es[n] = 1'b0;
            else if (k < 32) es[n] = m_txl[(2*n)*32 + 31 - k];
            else es[n] = m_txl[(2*n+1)*32 + 63 - k];
        end
        @(negedge clk);
        tg = "";
        if (m_halt) tg = "R8";
        else if (m_from_rst && t < 2*r) tg = "R10";
        tb = (tg == "") ? "R1" : tg;
        tl = (tg == "") ? "R3" : tg;
        if (tg != "") td = tg;
        else if (m_zero) td = "R9";
        else td = "R2 R5";
        chk(bclk === eb, tb, "bclk", VW'(bclk), VW'(eb));
        chk(lrclk === el, tl, "lrclk", VW'(lrclk), VW'(el));
        chk(sdout === es, td, "sdout", VW'(sdout), VW'(es));
        chk(frame_strobe === e_strobe, "R4", "frame_strobe", VW'(frame_strobe), VW'(e_strobe));
        chk(rx_valid === m_valid, "R7", "rx_valid", VW'(rx_valid), VW'(m_valid));
        if (m_valid) chk(rx_samples === m_rxo, "R6", "rx_samples", rx_samples, m_rxo);
        if (e_strobe) begin
            tseed++;
            fill_tx();
        end
        for (int n = 0; n < NL; n++) begin
            logic [31:0] w;
            w = rx_word(rseed, 2*n + ((k >= 32) ? 1 : 0));
            sdin[n] = w[31 - (k % 32)];
        end
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        n_chk = 0; n_fail = 0;
        t = 0; rseed = 0; tseed = 0; m_strobes = 0;
        m_halt = 0; m_from_rst = 1; m_zero = 0; m_valid = 0; e_strobe = 0;
        m_txl = '0; m_cap = '0; m_rxo = '0;
        rst = 1'b1; halt_cmd = 1'b0; div_ratio = 8'd4; tx_valid = 1'b1;
        sdin = '0;
        fill_tx();
        // Reset state and start-up sequence (R10), then nominal ratio of 4.
        run(3);
        rst = 1'b0;
        run(900);
        // Frames with no fresh samples send zero words (R9).
        tx_valid = 1'b0;
        run(300);
        tx_valid = 1'b1;
        run(300);
        // Halt, then restart at an odd ratio (R8, R1).
        halt_cmd = 1'b1;
        run(5);
        div_ratio = 8'd5;
        halt_cmd = 1'b0;
        run(1000);
        // Halt mid-frame, restart at the fastest ratio.
        halt_cmd = 1'b1;
        div_ratio = 8'd2;
        run(3);
        halt_cmd = 1'b0;
        run(500);
        // A ratio below the minimum is clamped (R1).
        halt_cmd = 1'b1;
        div_ratio = 8'd0;
        run(2);
        halt_cmd = 1'b0;
        run(400);
        // Reset mid-run, then a slower ratio.
        rst = 1'b1;
        div_ratio = 8'd6;
        run(2);
        rst = 1'b0;
        run(900);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule